// File: doc/BRIEF.md
# Binary-tree pseudo-LRU replacement unit

This block picks replacement ways for a set-associative cache. For each set it holds a small binary decision tree. The tree approximates least-recently-used order at a cost of one bit per way minus one. A cache controller reports every way it touches through a registered update port, giving the set index and the way index. It asks which way to evict through a separate combinational lookup port, giving a set index. A synchronous clear input puts every set back to its starting state, for example when the cache is invalidated. Tag comparison, hit detection and data storage belong to the surrounding cache.

Each set's tree has NUM_WAYS-1 bits stored in heap order: node 0 is the root, and node i has children 2i+1 and 2i+2. A bit of 0 steers the search towards the left child (the lower way numbers). A bit of 1 steers it towards the right child. Both NUM_WAYS and NUM_SETS must be powers of two. With NUM_WAYS equal to 1 the unit keeps no state and always nominates way 0.

Top module: `plru_tree_unit`

## Requirements
- R1: After reset, and in the cycle after a clear, every tree bit of every set is 0, so the victim of every set is way 0.
- R2: When way w is updated, leaf node (NUM_WAYS-1)/2 + w/2 is written with 1 if w is even and with 0 if w is odd. With 4 ways starting from all zeros, updating way 0 and then way 1 leaves a victim of way 2 each time.
- R3: When way w is updated, every ancestor of its leaf is written, up to the root. Each ancestor is written with the parity of the child index on the path (1 when the child index is odd). With 4 ways, after updates of ways 0, 1, 2 and 3 in that order, the victim after way 2 is way 0 and the victim after way 3 is way 0.
- R4: The victim is found by walking from the root: a 0 bit goes to child 2i+1 and a 1 bit goes to child 2i+2. The walk stops at a leaf index l, and the victim is 2*(l-(NUM_WAYS-1)/2), plus 1 when the leaf bit is 1. With 4 ways, updating way 0 and then way 2 from all zeros gives a victim of way 1.
- R5: Clear wins over an update presented in the same cycle. The updated set ends with all bits 0, so its victim is way 0.
- R6: An update changes only the tree of the set it addresses.
- R7: When update enable is low, no tree changes.
- R8: The victim output depends combinationally on the victim set input and the registered tree state. A change of the set input shows at the output in the same cycle.
- R9: With NUM_WAYS equal to 1, the victim is always way 0, whatever update or clear traffic arrives.
- R10: For NUM_WAYS of 2 or more, the way just updated is never the victim of its set in the following cycle. For NUM_WAYS of 4 or more, the victim lies in the other half of the ways from that way (its top way bit differs).

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Clock; all state changes on the rising edge |
| rst_ni | input | 1 | Asynchronous active-low reset; zeroes all trees |
| clr_i | input | 1 | Synchronous clear of every tree; wins over an update |
| upd_en_i | input | 1 | Marks a way as recently used on this edge |
| upd_set_i | input | SET_W | Set index of the update |
| upd_way_i | input | WAY_W | Way index of the update |
| vic_set_i | input | SET_W | Set index for the victim lookup |
| vic_way_o | output | WAY_W | Way to replace in set vic_set_i |

## Verification
The bound checker watches several properties on every cycle. A clear must give victim 0 on the next cycle. A way just touched must not come back as the victim. For four or more ways, the victim must sit in the other half of the ways. When the looked-up set was neither cleared nor updated, the victim must stay put. The exact bit encodings cannot be seen from a single cycle and need the bench's scenarios: the leaf polarity, the parity written into each ancestor, and the known victim sequences for four ways. The same holds for clear winning over a simultaneous update, and for the single-way variant ignoring all traffic.

// File: rtl/plru_pkg.sv
package plru_pkg;

   // Index width for a count, never below one bit.
   function automatic int unsigned idx_bits(input int unsigned n);
      return (n <= 1) ? 1 : $clog2(n);
   endfunction

   function automatic bit is_pow2(input int unsigned n);
      return (n != 0) && ((n & (n - 1)) == 0);
   endfunction

endpackage

// File: rtl/plru_tree_next.sv
module plru_tree_next #(
   parameter int unsigned NUM_WAYS = 8,
   localparam int unsigned NODE_W  = NUM_WAYS - 1,
   localparam int unsigned WAY_W   = plru_pkg::idx_bits(NUM_WAYS),
   localparam int unsigned IDX_W   = plru_pkg::idx_bits(NODE_W),
   localparam int unsigned LEVELS  = $clog2(NUM_WAYS),
   localparam int unsigned BASE    = (NUM_WAYS - 1) / 2
) (
   input  logic [NODE_W-1:0] tree_i,
   input  logic [WAY_W-1:0]  way_i,
   output logic [NODE_W-1:0] tree_o
);

   logic [IDX_W-1:0] node;
   logic [IDX_W-1:0] parent;

   always_comb begin
      tree_o       = tree_i;
      node         = IDX_W'(BASE) + IDX_W'(way_i >> 1);
      parent       = '0;
      // leaf remembers which sibling was used: point at the other one
      tree_o[node] = ~way_i[0];
      for (int lvl = 1; lvl < int'(LEVELS); lvl++) begin
         parent         = (node - IDX_W'(1)) >> 1;
         tree_o[parent] = node[0];
         node           = parent;
      end
   end

endmodule

// File: rtl/plru_victim_walk.sv
module plru_victim_walk #(
   parameter int unsigned NUM_WAYS = 8,
   localparam int unsigned NODE_W  = NUM_WAYS - 1,
   localparam int unsigned WAY_W   = plru_pkg::idx_bits(NUM_WAYS),
   localparam int unsigned IDX_W   = plru_pkg::idx_bits(NODE_W),
   localparam int unsigned LEVELS  = $clog2(NUM_WAYS),
   localparam int unsigned BASE    = (NUM_WAYS - 1) / 2
) (
   input  logic [NODE_W-1:0] tree_i,
   output logic [WAY_W-1:0]  victim_o
);

   logic [IDX_W-1:0] node;
   logic [WAY_W-1:0] pair;

   always_comb begin
      node = '0;
      for (int k = 0; k + 1 < int'(LEVELS); k++) begin
         node = tree_i[node] ? ((node << 1) + IDX_W'(2))
                             : ((node << 1) + IDX_W'(1));
      end
      pair     = WAY_W'(node - IDX_W'(BASE));
      victim_o = (pair << 1) | WAY_W'(tree_i[node]);
   end

endmodule

// File: rtl/plru_tree_store.sv
module plru_tree_store #(
   parameter int unsigned NUM_SETS = 16,
   parameter int unsigned NODE_W   = 7,
   localparam int unsigned SET_W   = plru_pkg::idx_bits(NUM_SETS)
) (
   input  logic              clk_i,
   input  logic              rst_ni,
   input  logic              clr_i,
   input  logic              wr_en_i,
   input  logic [SET_W-1:0]  wr_set_i,
   input  logic [NODE_W-1:0] wr_tree_i,
   input  logic [SET_W-1:0]  rd_a_set_i,
   output logic [NODE_W-1:0] rd_a_tree_o,
   input  logic [SET_W-1:0]  rd_b_set_i,
   output logic [NODE_W-1:0] rd_b_tree_o
);

   logic [NODE_W-1:0] tree_q [NUM_SETS];

   for (genvar s = 0; s < int'(NUM_SETS); s++) begin : g_set
      always_ff @(posedge clk_i or negedge rst_ni) begin
         if (!rst_ni) begin
            tree_q[s] <= '0;
         end else if (clr_i) begin
            tree_q[s] <= '0;
         end else if (wr_en_i && (wr_set_i == SET_W'(s))) begin
            tree_q[s] <= wr_tree_i;
         end
      end
   end

   assign rd_a_tree_o = tree_q[rd_a_set_i];
   assign rd_b_tree_o = tree_q[rd_b_set_i];

endmodule

// File: rtl/plru_tree_unit.sv
module plru_tree_unit #(
   parameter int unsigned NUM_SETS = 16,
   parameter int unsigned NUM_WAYS = 8,
   localparam int unsigned SET_W   = plru_pkg::idx_bits(NUM_SETS),
   localparam int unsigned WAY_W   = plru_pkg::idx_bits(NUM_WAYS)
) (
   input  logic             clk_i,
   input  logic             rst_ni,
   input  logic             clr_i,
   input  logic             upd_en_i,
   input  logic [SET_W-1:0] upd_set_i,
   input  logic [WAY_W-1:0] upd_way_i,
   input  logic [SET_W-1:0] vic_set_i,
   output logic [WAY_W-1:0] vic_way_o
);

   if (!plru_pkg::is_pow2(NUM_WAYS)) begin : g_bad_ways
      $error("plru_tree_unit: NUM_WAYS must be a power of two");
   end
   if (!plru_pkg::is_pow2(NUM_SETS) || NUM_SETS < 2) begin : g_bad_sets
      $error("plru_tree_unit: NUM_SETS must be a power of two, at least 2");
   end

   if (NUM_WAYS == 1) begin : g_single
      // one way: nothing to choose, no state kept
      logic unused_inputs;
      assign unused_inputs = ^{clk_i, rst_ni, clr_i, upd_en_i,
                               upd_set_i, upd_way_i, vic_set_i};
      assign vic_way_o = '0;
   end else begin : g_tree
      localparam int unsigned NODE_W = NUM_WAYS - 1;

      logic [NODE_W-1:0] cur_tree;
      logic [NODE_W-1:0] nxt_tree;
      logic [NODE_W-1:0] vic_tree;

      plru_tree_store #(
         .NUM_SETS (NUM_SETS),
         .NODE_W   (NODE_W)
      ) u_store (
         .clk_i       (clk_i),
         .rst_ni      (rst_ni),
         .clr_i       (clr_i),
         .wr_en_i     (upd_en_i),
         .wr_set_i    (upd_set_i),
         .wr_tree_i   (nxt_tree),
         .rd_a_set_i  (upd_set_i),
         .rd_a_tree_o (cur_tree),
         .rd_b_set_i  (vic_set_i),
         .rd_b_tree_o (vic_tree)
      );

      plru_tree_next #(
         .NUM_WAYS (NUM_WAYS)
      ) u_next (
         .tree_i (cur_tree),
         .way_i  (upd_way_i),
         .tree_o (nxt_tree)
      );

      plru_victim_walk #(
         .NUM_WAYS (NUM_WAYS)
      ) u_walk (
         .tree_i   (vic_tree),
         .victim_o (vic_way_o)
      );
   end

endmodule

// File: rtl/plru_tree_unit_chk.sv
module plru_tree_unit_chk #(
   parameter int unsigned NUM_SETS = 16,
   parameter int unsigned NUM_WAYS = 8,
   localparam int unsigned SET_W   = plru_pkg::idx_bits(NUM_SETS),
   localparam int unsigned WAY_W   = plru_pkg::idx_bits(NUM_WAYS)
) (
   input logic             clk_i,
   input logic             rst_ni,
   input logic             clr_i,
   input logic             upd_en_i,
   input logic [SET_W-1:0] upd_set_i,
   input logic [WAY_W-1:0] upd_way_i,
   input logic [SET_W-1:0] vic_set_i,
   input logic [WAY_W-1:0] vic_way_o
);

   // R1, R5: any clear leaves all trees empty, victim 0 next cycle
   a_r1_clear_gives_way0: assert property (@(posedge clk_i) disable iff (!rst_ni)
      clr_i |=> (vic_way_o == '0));

   // R6, R7: a set neither cleared nor updated keeps its victim
   a_r6_untouched_set_stable: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (!clr_i && !(upd_en_i && (upd_set_i == vic_set_i)))
      |=> (($past(vic_set_i) != vic_set_i) || $stable(vic_way_o)));

   if (NUM_WAYS >= 2) begin : g_multi
      // R10: the way just used is not nominated
      a_r10_recent_not_victim: assert property (@(posedge clk_i) disable iff (!rst_ni)
         (upd_en_i && !clr_i)
         |=> ((vic_set_i != $past(upd_set_i)) || (vic_way_o != $past(upd_way_i))));
   end

   if (NUM_WAYS >= 4) begin : g_wide
      // R3: root points to the half away from the way just used
      a_r3_root_other_half: assert property (@(posedge clk_i) disable iff (!rst_ni)
         (upd_en_i && !clr_i)
         |=> ((vic_set_i != $past(upd_set_i))
              || (vic_way_o[WAY_W-1] != $past(upd_way_i[WAY_W-1]))));
   end

endmodule

bind plru_tree_unit plru_tree_unit_chk #(
   .NUM_SETS (NUM_SETS),
   .NUM_WAYS (NUM_WAYS)
) u_chk (.*);

// File: tb/plru_tree_unit_bench.sv
module plru_tree_unit_bench;

   localparam int unsigned SETS  = 8;
   localparam int unsigned WAYS  = 4;
   localparam int unsigned SET_W = 3;
   localparam int unsigned WAY_W = 2;

   logic             clk = 1'b0;
   logic             rst_n = 1'b0;
   logic             clr = 1'b0;
   logic             upd_en = 1'b0;
   logic [SET_W-1:0] upd_set = '0;
   logic [WAY_W-1:0] upd_way = '0;
   logic             upd_way1 = 1'b0;
   logic [SET_W-1:0] vic_set = '0;
   logic [WAY_W-1:0] vic_way;
   logic             vic_way1;

   int unsigned n_tests = 0;
   int unsigned n_fail  = 0;
   logic [2:0]  mtree [SETS];

   always #4 clk = ~clk;

   plru_tree_unit #(.NUM_SETS(SETS), .NUM_WAYS(WAYS)) u_plru_tree_unit (
      .clk_i(clk), .rst_ni(rst_n), .clr_i(clr), .upd_en_i(upd_en),
      .upd_set_i(upd_set), .upd_way_i(upd_way), .vic_set_i(vic_set),
      .vic_way_o(vic_way));

   plru_tree_unit #(.NUM_SETS(SETS), .NUM_WAYS(1)) u_plru_tree_unit_w1 (
      .clk_i(clk), .rst_ni(rst_n), .clr_i(clr), .upd_en_i(upd_en),
      .upd_set_i(upd_set), .upd_way_i(upd_way1), .vic_set_i(vic_set),
      .vic_way_o(vic_way1));

   // expected tree after touching way w (4 ways, bits [root, left, right])
   function automatic logic [2:0] exp_update(input logic [2:0] t, input int w);
      int leaf;
      leaf    = 1 + w / 2;
      t[leaf] = (w % 2 == 0);
      t[0]    = leaf[0];
      return t;
   endfunction

   function automatic int exp_victim(input logic [2:0] t);
      int leaf;
      leaf = t[0] ? 2 : 1;
      return 2 * (leaf - 1) + int'(t[leaf]);
   endfunction

   task automatic check(input string req, input int act, input int exp);
      n_tests++;
      if (act != exp) begin
         n_fail++;
         $display("FAIL %s: actual %0d expected %0d", req, act, exp);
      end
   endtask

   // one clock: present inputs at a falling edge, mirror at the next one
   task automatic cycle(input logic c, input logic e, input int s, input int w);
      clr = c; upd_en = e; upd_set = SET_W'(s); upd_way = WAY_W'(w);
      upd_way1 = 1'($urandom);
      @(negedge clk);
      if (c) begin
         for (int i = 0; i < int'(SETS); i++) mtree[i] = '0;
      end else if (e) begin
         mtree[s] = exp_update(mtree[s], w);
      end
      clr = 1'b0; upd_en = 1'b0;
   endtask

   task automatic peek(input string req, input int s);
      vic_set = SET_W'(s);
      #1;
      check(req, int'(vic_way), exp_victim(mtree[s]));
   endtask

   initial begin
      #(8 * 200000);
      n_fail++;
      $display("FAIL watchdog: run did not end, actual hung expected done");
      $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
   end

   initial begin
      void'($urandom(32'h0051_7EED));
      for (int i = 0; i < int'(SETS); i++) mtree[i] = '0;
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);

      // R1: reset state
      for (int s = 0; s < int'(SETS); s++) begin
         vic_set = SET_W'(s); #1;
         check("R1 reset", int'(vic_way), 0);
      end

      // R2/R3: fill order on set 3
      cycle(0, 1, 3, 0); vic_set = 3; #1; check("R2 after way0", int'(vic_way), 2);
      cycle(0, 1, 3, 1); vic_set = 3; #1; check("R2 after way1", int'(vic_way), 2);
      cycle(0, 1, 3, 2); vic_set = 3; #1; check("R3 after way2", int'(vic_way), 0);
      cycle(0, 1, 3, 3); vic_set = 3; #1; check("R3 after way3", int'(vic_way), 0);

      // R1: clear, then R4 walk ending in an odd way
      cycle(1, 0, 0, 0);
      vic_set = 3; #1; check("R1 clear", int'(vic_way), 0);
      cycle(0, 1, 3, 0);
      cycle(0, 1, 3, 2); vic_set = 3; #1; check("R4 walk to way1", int'(vic_way), 1);

      // R5: clear beats update in the same cycle
      cycle(0, 1, 5, 0);
      peek("R5 setup", 5);
      cycle(1, 1, 5, 1); vic_set = 5; #1; check("R5 clear wins", int'(vic_way), 0);

      // R6: only addressed set changes
      cycle(0, 1, 2, 0);
      vic_set = 1; #1; check("R6 other set", int'(vic_way), 0);
      vic_set = 2; #1; check("R6 own set", int'(vic_way), 2);

      // R7: enable low writes nothing
      cycle(0, 0, 4, 0); vic_set = 4; #1; check("R7 disabled", int'(vic_way), 0);

      // R8: lookup follows the set input within a cycle
      vic_set = 2; #1; check("R8 comb a", int'(vic_way), 2);
      vic_set = 4; #1; check("R8 comb b", int'(vic_way), 0);

      // random traffic against the model, R10 after each update
      for (int it = 0; it < 400; it++) begin
         int op, s, w;
         op = int'($urandom % 10);
         s  = int'($urandom % SETS);
         w  = int'($urandom % WAYS);
         if (op == 0) cycle(1, $urandom % 2, s, w);
         else if (op < 8) begin
            cycle(0, 1, s, w);
            vic_set = SET_W'(s); #1;
            n_tests++;
            if (int'(vic_way) == w) begin
               n_fail++;
               $display("FAIL R10: actual %0d expected not %0d", vic_way, w);
            end
         end
         else cycle(0, 0, s, w);
         peek("R4 random", int'($urandom % SETS));
         check("R9 single way", int'(vic_way1), 0);
      end

      $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
   end

endmodule